// File: doc/BRIEF.md
# Streaming Histogram Equaliser with Previous-Frame Mapping

This block equalises the grey levels of an 8-bit monochrome pixel stream. Pixels arrive with a valid strobe, and a vertical-sync marker separates the frames. While a frame streams through, the block counts how many pixels fall on each grey level. When the frame ends, it walks the counts in ascending level order and builds a cumulative, normalised lookup table. Each output value is `floor(cumulative_count * 255 / pixel_total)`.

The pixels of a frame are remapped through the table built from the frame before it. Because the table is always one frame old, no frame store is needed. There are two histogram banks and two table banks. One histogram bank counts the new frame while the other is read out and cleared. The new table is written into the idle table bank and becomes active only when the walk over all 256 levels has finished.

Scaling uses only shifts and adds. One variant handles frames whose pixel total is a power of two. The other handles totals of five times a power of two; 640x512 is one of these.

Top module: `hist_equalizer`

## Requirements
- R1: The histogram counts only pixels sampled with `din_valid` high. A pixel value presented while `din_valid` is low affects no later table entry.
- R2: Table entry D equals `floor(C(D) * 255 / (FRAME_W*FRAME_H))`. C(D) is the number of counted pixels of the finished frame with a level from 0 to D.
- R3: A frame ends at the clock edge where `vsync` is sampled low after being sampled high on the previous edge. The table computed from that frame applies to pixels sampled 257 or more edges after that edge. Pixels sampled on edges 1 to 256 after it still use the previous table.
- R4: Until the first table has been activated after reset, `dout` equals the input pixel.
- R5: Each frame's table depends only on the pixels of that frame. The counts of earlier frames are cleared.
- R6: A table entry whose scaled value would exceed 255 is clamped to 255.
- R7: `dout_valid` is `din_valid` delayed by exactly 6 clock cycles, and `dout` carries the mapped pixel in that same cycle. Both are 0 after reset.
- R8: `vsync_out` follows `vsync` without delay.
- R9: Both scaling variants are supported: a power-of-two pixel total, and a pixel total of 5 times a power of two (for example 640x512). Both give the R2 result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din_valid | input | 1 | Input pixel qualifier |
| din | input | PIX_W | Input grey level |
| vsync | input | 1 | Frame marker; its falling edge closes a frame |
| dout | output | PIX_W | Remapped grey level |
| dout_valid | output | 1 | Output pixel qualifier, `din_valid` delayed 6 cycles |
| vsync_out | output | 1 | Pass-through of `vsync` |

## Verification
The hardest situation to reach is the 256-cycle window after a frame end. During this window the next frame is already being counted into the fresh bank, but its pixels must still be mapped through the older table. The stimulus starts the next frame on the cycle right after the falling sync and makes it longer than the window. As a result, a single frame contains pixels on both sides of the table swap, and the bench predicts the bank for each pixel from its sampling edge. Saturation is reached by sending a frame with more pixels than the nominal frame size.

// File: rtl/heq_pkg.sv
// Shared definitions for the histogram equaliser.
// Assumes pixel totals are either a power of two or five times one.
package heq_pkg;

    typedef enum logic {
        SCALE_POW2,
        SCALE_FIVE
    } scale_mode_e;

    // Chooses the shift-and-add scaling variant for a frame pixel total.
    function automatic scale_mode_e pick_mode(input int total);
        if ((total & (total - 1)) == 0) return SCALE_POW2;
        return SCALE_FIVE;
    endfunction

endpackage

// File: rtl/heq_hist_bank.sv
// Two banks of per-level pixel counters.
// One bank counts the current frame. The other is read and cleared entry
// by entry during the cumulative walk. Assumes that the counting bank is
// never the bank being cleared.
module heq_hist_bank #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_vld,
    input  logic [PIX_W-1:0] pix,
    input  logic             cnt_bank,
    input  logic             clr_en,
    input  logic [PIX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam int LEVELS = 1 << PIX_W;

    logic [CNT_W-1:0] cnt_q [2][LEVELS];

    // Count valid pixels in the active bank and clear swept entries in the other.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int l = 0; l < LEVELS; l++)
                    cnt_q[b][l] <= '0;
        end else begin
            if (pix_vld)
                cnt_q[cnt_bank][pix] <= cnt_q[cnt_bank][pix] + CNT_W'(1);
            if (clr_en)
                cnt_q[~cnt_bank][rd_idx] <= '0;
        end
    end

    // Read port for the cumulative walk, always on the idle bank.
    always_comb rd_cnt = cnt_q[~cnt_bank][rd_idx];

    // R5: a swept entry is zero on the following cycle.
    a_r5_clr_entry: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (cnt_q[~$past(cnt_bank)][$past(rd_idx)] == '0));

endmodule

// File: rtl/heq_cdf_sweep.sv
// Detects the end of a frame and runs the 256-step cumulative walk.
// It flips the counting bank at frame end. It emits one scaled table write
// per level and a swap pulse on the final write. A frame end that arrives
// while a walk is running is ignored, so frames must be longer than the
// walk.
module heq_cdf_sweep #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 20,
    parameter int TOTAL = 327680
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    input  logic [CNT_W-1:0] rd_cnt,
    output logic             cnt_bank,
    output logic             busy,
    output logic [PIX_W-1:0] idx,
    output logic             tbl_wr_en,
    output logic [PIX_W-1:0] tbl_wr_val,
    output logic             tbl_swap
);
    import heq_pkg::*;

    localparam int LEVELS = 1 << PIX_W;
    localparam int ACC_W  = CNT_W + 1;
    localparam int PROD_W = ACC_W + PIX_W;
    localparam int MAXV   = LEVELS - 1;

    logic              vs_q;
    logic              frame_end;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  sum;
    logic [PROD_W-1:0] prod;
    logic              last;

    always_comb frame_end = vs_q & ~vsync;
    always_comb sum       = acc + ACC_W'(rd_cnt);
    always_comb last      = busy && (idx == PIX_W'(LEVELS - 1));

    // Scale the running sum by max grey over pixel total, using shifts and adds only.
    if (pick_mode(TOTAL) == SCALE_POW2) begin : g_pow2
        localparam int SH = $clog2(TOTAL);
        always_comb prod = ({sum, {PIX_W{1'b0}}} - {{PIX_W{1'b0}}, sum}) >> SH;
    end else begin : g_five
        localparam int SH = $clog2(TOTAL / 5);
        // 255/5 = 51 = 32 + 16 + 2 + 1
        always_comb prod = ({{(PIX_W-5){1'b0}}, sum, 5'b0}
                          + {{(PIX_W-4){1'b0}}, sum, 4'b0}
                          + {{(PIX_W-1){1'b0}}, sum, 1'b0}
                          + {{PIX_W{1'b0}}, sum}) >> SH;
    end

    // Clamp the scaled value to the largest grey level.
    always_comb tbl_wr_val = (prod > PROD_W'(MAXV)) ? PIX_W'(MAXV) : prod[PIX_W-1:0];

    always_comb tbl_wr_en = busy;
    always_comb tbl_swap  = last;

    // Track sync, start a walk at frame end and step it one level per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q     <= 1'b0;
            cnt_bank <= 1'b0;
            busy     <= 1'b0;
            idx      <= '0;
            acc      <= '0;
        end else begin
            vs_q <= vsync;
            if (frame_end && !busy) begin
                cnt_bank <= ~cnt_bank;
                busy     <= 1'b1;
                idx      <= '0;
                acc      <= '0;
            end else if (busy) begin
                acc <= sum;
                idx <= idx + PIX_W'(1);
                if (last) busy <= 1'b0;
            end
        end
    end

    // R3: a walk only begins on the cycle after a falling sync.
    a_r3_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(vs_q) && !$past(vsync)));

    // R2: cumulative table entries never decrease within one walk.
    a_r2_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr_en && idx != '0) |-> (tbl_wr_val >= $past(tbl_wr_val)));

    // R3: a swap is the final step of a running walk.
    a_r3_swap_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_swap |=> !busy);

endmodule

// File: rtl/heq_map_pipe.sv
// Double-buffered lookup tables and the fixed-latency output pipeline.
// Both table banks reset to identity. Writes go to the idle bank, and the
// swap pulse makes that bank active from the next cycle.
module heq_map_pipe #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_valid,
    input  logic [PIX_W-1:0] din,
    input  logic             tbl_wr_en,
    input  logic [PIX_W-1:0] tbl_wr_idx,
    input  logic [PIX_W-1:0] tbl_wr_val,
    input  logic             tbl_swap,
    output logic [PIX_W-1:0] dout,
    output logic             dout_valid
);
    localparam int LEVELS = 1 << PIX_W;
    localparam int LAT    = 6;

    logic [PIX_W-1:0] tbl_q [2][LEVELS];
    logic             tbl_sel;
    logic [PIX_W-1:0] pix_p [LAT];
    logic             vld_p [LAT];

    // Load identity at reset, fill the idle bank during a walk, flip on swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_sel <= 1'b0;
            for (int b = 0; b < 2; b++)
                for (int l = 0; l < LEVELS; l++)
                    tbl_q[b][l] <= PIX_W'(l);
        end else begin
            if (tbl_wr_en) tbl_q[~tbl_sel][tbl_wr_idx] <= tbl_wr_val;
            if (tbl_swap)  tbl_sel <= ~tbl_sel;
        end
    end

    // First stage: look up the incoming pixel in the active bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_p[0] <= '0;
            vld_p[0] <= 1'b0;
        end else begin
            pix_p[0] <= tbl_q[tbl_sel][din];
            vld_p[0] <= din_valid;
        end
    end

    // Remaining stages: plain delay to the fixed output latency.
    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pix_p[s] <= '0;
                vld_p[s] <= 1'b0;
            end else begin
                pix_p[s] <= pix_p[s-1];
                vld_p[s] <= vld_p[s-1];
            end
        end
    end

    always_comb dout       = pix_p[LAT-1];
    always_comb dout_valid = vld_p[LAT-1];

    // Checker state: cycles since reset, saturating at the latency.
    logic [2:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 3'(LAT)) age_q <= age_q + 3'd1;
    end

    // R7: output valid is the input valid from six cycles earlier.
    a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 3'(LAT)) |-> (dout_valid == $past(din_valid, 6)));

endmodule

// File: rtl/hist_equalizer.sv
// Streaming grey-level equaliser. Each frame is mapped through the
// cumulative table built from the preceding frame. Assumes that frame ends
// are more than 257 cycles apart and that the pixel total is a power of two
// or five times a power of two.
module hist_equalizer #(
    parameter int PIX_W   = 8,
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din_valid,
    input  logic [PIX_W-1:0] din,
    input  logic             vsync,
    output logic [PIX_W-1:0] dout,
    output logic             dout_valid,
    output logic             vsync_out
);
    localparam int TOTAL = FRAME_W * FRAME_H;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic             cnt_bank;
    logic             busy;
    logic [PIX_W-1:0] idx;
    logic [CNT_W-1:0] rd_cnt;
    logic             wr_en;
    logic [PIX_W-1:0] wr_val;
    logic             swap;

    heq_hist_bank #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .pix_vld(din_valid), .pix(din),
        .cnt_bank(cnt_bank), .clr_en(busy), .rd_idx(idx), .rd_cnt(rd_cnt)
    );

    heq_cdf_sweep #(.PIX_W(PIX_W), .CNT_W(CNT_W), .TOTAL(TOTAL)) u_sweep (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .rd_cnt(rd_cnt),
        .cnt_bank(cnt_bank), .busy(busy), .idx(idx), .tbl_wr_en(wr_en),
        .tbl_wr_val(wr_val), .tbl_swap(swap)
    );

    heq_map_pipe #(.PIX_W(PIX_W)) u_map (
        .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din(din),
        .tbl_wr_en(wr_en), .tbl_wr_idx(idx), .tbl_wr_val(wr_val),
        .tbl_swap(swap), .dout(dout), .dout_valid(dout_valid)
    );

    // R8: the sync marker passes straight through.
    always_comb vsync_out = vsync;

endmodule

// File: tb/test_hist_equalizer.sv
module test_hist_equalizer;
    localparam int TOT_N = 256;   // 16x16, power-of-two variant
    localparam int TOT_W = 1280;  // 40x32, five-times-power-of-two variant

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din_valid = 1'b0;
    logic [7:0] din = '0;
    logic vsync = 1'b0;
    logic [7:0] dout_n, dout_w;
    logic dv_n, dv_w, vso_n, vso_w;

    always #10 clk = ~clk;

    hist_equalizer #(.PIX_W(8), .FRAME_W(16), .FRAME_H(16)) i_hist_equalizer (
        .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din(din), .vsync(vsync),
        .dout(dout_n), .dout_valid(dv_n), .vsync_out(vso_n));

    hist_equalizer #(.PIX_W(8), .FRAME_W(40), .FRAME_H(32)) i_hist_equalizer_wide (
        .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din(din), .vsync(vsync),
        .dout(dout_w), .dout_valid(dv_w), .vsync_out(vso_w));

    typedef struct { int due; int en; int ew; } exp_t;
    exp_t sb[$];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int cur_n[256], cur_w[256], pend_n[256], pend_w[256], hist[256];
    bit pend_on = 0;
    int pend_edge = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: one pixel per call, sampled at the next rising edge.
    task automatic drive(input bit v, input int p);
        int e;
        exp_t x;
        @(negedge clk);
        e = cyc + 1;
        din_valid = v;
        din = 8'(p);
        if (v) begin
            if (pend_on && e >= pend_edge) begin   // R3: new table after the walk
                cur_n = pend_n; cur_w = pend_w; pend_on = 0;
            end
            x.due = e + 5;                         // R7: visible 6 cycles later
            x.en = cur_n[p & 255];
            x.ew = cur_w[p & 255];
            sb.push_back(x);
            hist[p & 255]++;                       // R1: only valid pixels count
        end
    endtask

    // Frame end: sync high one cycle, then low; compute the next table (R2, R6).
    task automatic frame_end();
        int cum, ef;
        @(negedge clk);
        din_valid = 0; vsync = 1;
        @(negedge clk);
        vsync = 0;
        ef = cyc + 1;
        cum = 0;
        for (int l = 0; l < 256; l++) begin
            cum += hist[l];
            pend_n[l] = (cum * 255) / TOT_N; if (pend_n[l] > 255) pend_n[l] = 255;
            pend_w[l] = (cum * 255) / TOT_W; if (pend_w[l] > 255) pend_w[l] = 255;
            hist[l] = 0;                           // R5: fresh histogram
        end
        pend_on = 1;
        pend_edge = ef + 257;
    endtask

    // Monitor: pops the scoreboard when outputs are due, away from the edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            check(vso_n == vsync && vso_w == vsync, "R8 vsync pass", int'(vso_n), int'(vsync));
            if (sb.size() > 0 && sb[0].due == cyc) begin
                check(dv_n && dv_w, "R7 valid timing", int'(dv_n), 1);
                check(int'(dout_n) == sb[0].en, "R2/R3/R4/R6 narrow map", int'(dout_n), sb[0].en);
                check(int'(dout_w) == sb[0].ew, "R9 wide map", int'(dout_w), sb[0].ew);
                void'(sb.pop_front());
            end else if (dv_n || dv_w) begin
                check(0, "R7 unexpected valid", int'(dv_n), 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < 256; l++) begin
            cur_n[l] = l; cur_w[l] = l; hist[l] = 0;   // R4: identity at start
        end
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(dv_n == 0 && dv_w == 0, "R7 reset valid", int'(dv_n), 0);
        check(dout_n == 0 && dout_w == 0, "R7 reset data", int'(dout_n), 0);
        rst_n = 1;

        // Frame A: levels 0..63 four times each, with invalid noise (R1, R4).
        for (int i = 0; i < 256; i++) begin
            drive(1, i >> 2);
            if (i % 16 == 0) drive(0, 250);
        end
        frame_end();

        // Frame B straight after the sync: spans the walk window (R3), 300 pixels (R6).
        for (int i = 0; i < 300; i++) drive(1, (i * 37) & 255);
        repeat (300) drive(0, 255);
        frame_end();

        // Frame C: mapped with table B, saturated at the top (R6); bottom-heavy content.
        for (int i = 0; i < 256; i++) drive(1, (i * 5) & 127);
        repeat (300) drive(0, 0);
        frame_end();

        // Frame D: table C only, earlier counts cleared (R5).
        repeat (300) drive(0, 9);
        for (int i = 0; i < 256; i++) drive(1, 255 - i);
        drive(0, 0);
        repeat (12) @(negedge clk);
        check(sb.size() == 0, "R7 all outputs seen", sb.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule